// File: doc/BRIEF.md
# Logic Self-Test Pattern Source and Response Compactor

This block pairs two 61-stage linear-feedback registers for at-speed logic self-test. The pattern source fans out to 61 parallel scan channels; each channel value is its own stage XORed with stage 0, so neighbouring channels do not carry shifted copies of the same sequence. The response compactor folds 61 channel responses into its state on every shift cycle and leaves a signature.

A test controller first writes a starting seed into both registers in parallel. It then pulses the shift strobe once per scan cycle and holds it low during capture clocks. When the run ends, it presents the precomputed good signature and reads the match flag. A seed of all zeros for the pattern source is refused, because that state would never change.

Top module: `lbist_prpg_misr`

## Requirements
- R1: After a synchronous reset the pattern source holds 1 (stage 0 set, all other stages clear), the compactor holds zero and the seed error flag is low.
- R2: On a shift cycle without a load, pattern source stage i takes old stage i+1 for i from 0 to 59, and stage 60 takes the XOR of old stages 0, 14, 15 and 60.
- R3: Channel output i always equals pattern source stage i XOR pattern source stage 0, so channel 0 is always 0.
- R4: On a shift cycle without a load, compactor stage i takes old stage i+1 XOR response input i for i below 60, and stage 60 takes the XOR of old compactor stages 0, 14, 15, 60 and response input 60.
- R5: With both load and shift low, both registers keep their values and the response inputs have no effect.
- R6: A load with a nonzero pattern seed writes both seeds in the next cycle and takes precedence over a shift in the same cycle.
- R7: A load whose pattern seed is all zeros leaves both registers unchanged and raises the seed error flag in the next cycle. The flag stays high until a load with a nonzero pattern seed clears it.
- R8: The match flag is high exactly when the current compactor state equals the expected signature input, in the same cycle.
- R9: The pattern source never holds the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Write both seeds this cycle |
| gen_seed | input | 61 | Starting value for the pattern source |
| sig_seed | input | 61 | Starting value for the compactor |
| shift_en | input | 1 | Scan shift strobe; advances both registers |
| resp_in | input | 61 | Channel responses folded into the compactor |
| chan_out | output | 61 | Spread pattern channel values |
| gen_state | output | 61 | Current pattern source state |
| sig_state | output | 61 | Current signature |
| expect_sig | input | 61 | Precomputed good signature |
| sig_match | output | 1 | Signature equals expected value |
| seed_err | output | 1 | Last load offered an all-zero pattern seed |

## Verification
A wrong tap or a reversed shift in either register shows at gen_state or sig_state one cycle after the first shift strobe. It spreads to more stages on every later shift, so a multi-cycle run against a bench model catches it quickly. A spreading fault shows at chan_out in the same cycle as the state it comes from. A missed hold or a wrongly accepted zero seed shows one cycle after the offending strobe. A stale or inverted compare shows at sig_match as soon as the expected input changes.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    localparam int LBIST_W = 61;
    localparam logic [LBIST_W-1:0] LBIST_TAPS =
        (61'b1 << 0) | (61'b1 << 14) | (61'b1 << 15) | (61'b1 << 60);
    localparam logic [LBIST_W-1:0] LBIST_RESET_SEED = 61'h1;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_SHIFT  = 2'd1,
        OP_LOAD   = 2'd2,
        OP_REJECT = 2'd3
    } lbist_op_e;

    typedef struct packed {
        logic load;
        logic shift;
        logic seed_zero;
    } lbist_req_t;

    function automatic lbist_op_e decode_op(input lbist_req_t req);
        if (req.load)
            return req.seed_zero ? OP_REJECT : OP_LOAD;
        else if (req.shift)
            return OP_SHIFT;
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
    import lbist_pkg::*;
#(
    parameter int W = LBIST_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic         shift_en,
    input  logic [W-1:0] gen_seed,
    output lbist_op_e    op,
    output logic         seed_err
);

    lbist_req_t req;

    always_comb begin
        req.load      = load_en;
        req.shift     = shift_en;
        req.seed_zero = (gen_seed == '0);
        op            = decode_op(req);
    end

    always_ff @(posedge clk) begin
        if (rst)
            seed_err <= 1'b0;
        else if (op == OP_REJECT)
            seed_err <= 1'b1;
        else if (op == OP_LOAD)
            seed_err <= 1'b0;
    end

    assert_zero_seed_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (load_en && gen_seed == '0) |=> seed_err);

    assert_good_seed_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (load_en && gen_seed != '0) |=> !seed_err);

endmodule

// File: rtl/lbist_prpg.sv
module lbist_prpg
    import lbist_pkg::*;
#(
    parameter int           W      = LBIST_W,
    parameter logic [W-1:0] TAPS   = LBIST_TAPS,
    parameter logic [W-1:0] RSEED  = LBIST_RESET_SEED
) (
    input  logic         clk,
    input  logic         rst,
    input  lbist_op_e    op,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state,
    output logic [W-1:0] chan
);

    localparam int TOP = W - 1;

    logic [W-1:0] stepped;
    logic         fb;

    assign fb = ^(state & TAPS);

    genvar gi;
    generate
        for (gi = 0; gi < TOP; gi++) begin : g_shift
            assign stepped[gi] = state[gi+1];
        end
        for (gi = 0; gi < W; gi++) begin : g_spread
            assign chan[gi] = state[gi] ^ state[0];
        end
    endgenerate
    assign stepped[TOP] = fb;

    always_ff @(posedge clk) begin
        if (rst)
            state <= RSEED;
        else begin
            case (op)
                OP_LOAD:  state <= seed;
                OP_SHIFT: state <= stepped;
                default:  state <= state;
            endcase
        end
    end

    assert_gen_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    assert_gen_shift_dir_R2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> state[TOP-1:0] == $past(state[TOP:1]));

    assert_gen_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD || op == OP_REJECT) |=> $stable(state));

    assert_gen_load_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> state == $past(seed));

endmodule

// File: rtl/lbist_misr.sv
module lbist_misr
    import lbist_pkg::*;
#(
    parameter int           W    = LBIST_W,
    parameter logic [W-1:0] TAPS = LBIST_TAPS
) (
    input  logic         clk,
    input  logic         rst,
    input  lbist_op_e    op,
    input  logic [W-1:0] seed,
    input  logic [W-1:0] resp,
    output logic [W-1:0] state
);

    localparam int TOP = W - 1;

    logic [W-1:0] folded;
    logic         fb;

    assign fb = ^(state & TAPS);

    genvar gi;
    generate
        for (gi = 0; gi < TOP; gi++) begin : g_fold
            assign folded[gi] = state[gi+1] ^ resp[gi];
        end
    endgenerate
    assign folded[TOP] = fb ^ resp[TOP];

    always_ff @(posedge clk) begin
        if (rst)
            state <= '0;
        else begin
            case (op)
                OP_LOAD:  state <= seed;
                OP_SHIFT: state <= folded;
                default:  state <= state;
            endcase
        end
    end

    assert_sig_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD || op == OP_REJECT) |=> $stable(state));

    assert_sig_zero_resp_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT && resp == '0) |=>
            state[TOP-1:0] == $past(state[TOP:1]));

endmodule

// File: rtl/lbist_prpg_misr.sv
module lbist_prpg_misr
    import lbist_pkg::*;
#(
    parameter int           W    = LBIST_W,
    parameter logic [W-1:0] TAPS = LBIST_TAPS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic [W-1:0] gen_seed,
    input  logic [W-1:0] sig_seed,
    input  logic         shift_en,
    input  logic [W-1:0] resp_in,
    output logic [W-1:0] chan_out,
    output logic [W-1:0] gen_state,
    output logic [W-1:0] sig_state,
    input  logic [W-1:0] expect_sig,
    output logic         sig_match,
    output logic         seed_err
);

    lbist_op_e op;

    lbist_ctrl #(.W(W)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .shift_en (shift_en),
        .gen_seed (gen_seed),
        .op       (op),
        .seed_err (seed_err)
    );

    lbist_prpg #(.W(W), .TAPS(TAPS), .RSEED(LBIST_RESET_SEED)) prpg_i (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .seed  (gen_seed),
        .state (gen_state),
        .chan  (chan_out)
    );

    lbist_misr #(.W(W), .TAPS(TAPS)) misr_i (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .seed  (sig_seed),
        .resp  (resp_in),
        .state (sig_state)
    );

    assign sig_match = (sig_state == expect_sig);

    assert_chan0_low_R3: assert property (@(posedge clk) disable iff (rst)
        chan_out[0] == 1'b0);

    assert_reject_keeps_sig_R7: assert property (@(posedge clk) disable iff (rst)
        (load_en && gen_seed == '0) |=> $stable(sig_state) && $stable(gen_state));

endmodule

// File: tb/lbist_prpg_misr_tb.sv
module lbist_prpg_misr_tb_top;

    localparam int W = 61;

    logic         clk = 1'b0;
    logic         rst;
    logic         load_en;
    logic [W-1:0] gen_seed, sig_seed, resp_in, expect_sig;
    logic         shift_en;
    logic [W-1:0] chan_out, gen_state, sig_state;
    logic         sig_match, seed_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [W-1:0] m_gen, m_sig;
    logic         m_err;

    always #5 clk = ~clk;

    lbist_prpg_misr dut_i (
        .clk(clk), .rst(rst), .load_en(load_en), .gen_seed(gen_seed),
        .sig_seed(sig_seed), .shift_en(shift_en), .resp_in(resp_in),
        .chan_out(chan_out), .gen_state(gen_state), .sig_state(sig_state),
        .expect_sig(expect_sig), .sig_match(sig_match), .seed_err(seed_err)
    );

    function automatic logic tapx(input logic [W-1:0] s);
        return s[0] ^ s[14] ^ s[15] ^ s[60];
    endfunction

    function automatic logic [W-1:0] gen_step(input logic [W-1:0] s);
        logic [W-1:0] n;
        for (int i = 0; i < W-1; i++) n[i] = s[i+1];
        n[W-1] = tapx(s);
        return n;
    endfunction

    function automatic logic [W-1:0] sig_step(input logic [W-1:0] s, input logic [W-1:0] d);
        logic [W-1:0] n;
        for (int i = 0; i < W-1; i++) n[i] = s[i+1] ^ d[i];
        n[W-1] = tapx(s) ^ d[W-1];
        return n;
    endfunction

    function automatic logic [W-1:0] spread(input logic [W-1:0] s);
        logic [W-1:0] c;
        for (int i = 0; i < W; i++) c[i] = s[i] ^ s[0];
        return c;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model, sample at the next negedge.
    task automatic cycle(input logic ld, input logic sh, input logic [W-1:0] gs,
                         input logic [W-1:0] ss, input logic [W-1:0] d);
        load_en = ld; shift_en = sh; gen_seed = gs; sig_seed = ss; resp_in = d;
        if (ld) begin
            if (gs == '0) m_err = 1'b1;
            else begin m_gen = gs; m_sig = ss; m_err = 1'b0; end
        end else if (sh) begin
            m_sig = sig_step(m_sig, d);
            m_gen = gen_step(m_gen);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " gen R2"}, gen_state, m_gen);
        chk({tag, " sig R4"}, sig_state, m_sig);
        chk({tag, " chan R3"}, chan_out, spread(m_gen));
        chk({tag, " err R7"}, {60'b0, seed_err}, {60'b0, m_err});
    endtask

    task automatic t_reset();
        rst = 1'b1; load_en = 0; shift_en = 0; gen_seed = '0; sig_seed = '0;
        resp_in = '0; expect_sig = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        m_gen = 61'h1; m_sig = '0; m_err = 0;
        chk("R1 gen", gen_state, 61'h1);
        chk("R1 sig", sig_state, '0);
        chk("R1 err", {60'b0, seed_err}, '0);
    endtask

    task automatic t_load_and_free_run();
        cycle(1, 0, 61'h1ABC_DEF0_1234_5678, 61'h0F0F_0F0F_0F0F_0F0F, '0);
        chk("R6 gen load", gen_state, 61'h1ABC_DEF0_1234_5678);
        chk("R6 sig load", sig_state, 61'h0F0F_0F0F_0F0F_0F0F);
        for (int k = 0; k < 80; k++) begin
            cycle(0, 1, '0, '0, '0);
            compare_all("R2 zero-resp run");
        end
    endtask

    task automatic t_patterns();
        logic [W-1:0] d;
        for (int k = 0; k < 40; k++) begin
            d = {W{1'b1}};
            cycle(0, 1, '0, '0, d);
            compare_all("R4 all-ones resp");
        end
        for (int k = 0; k < 40; k++) begin
            d = (k % 2 == 0) ? {31{2'b01}} : {31{2'b10}};
            cycle(0, 1, '0, '0, d);
            compare_all("R4 checker resp");
        end
        for (int k = 0; k < W; k++) begin
            d = '0; d[k] = 1'b1;
            cycle(0, 1, '0, '0, d);
            compare_all("R4 walking-one resp");
        end
    endtask

    task automatic t_hold();
        for (int k = 0; k < 5; k++) begin
            cycle(0, 0, '0, '0, {W{1'b1}});
            compare_all("R5 hold");
        end
    endtask

    task automatic t_load_wins();
        cycle(1, 1, 61'h0000_0000_0000_8001, 61'h1FFF_FFFF_0000_0000, {W{1'b1}});
        chk("R6 load over shift gen", gen_state, 61'h0000_0000_0000_8001);
        chk("R6 load over shift sig", sig_state, 61'h1FFF_FFFF_0000_0000);
        cycle(0, 1, '0, '0, 61'h5);
        compare_all("R2 after load");
    endtask

    task automatic t_zero_seed();
        cycle(1, 1, '0, 61'h1234, {W{1'b1}});
        compare_all("R7 zero seed rejected");
        chk("R9 gen nonzero", {60'b0, gen_state == '0}, '0);
        cycle(0, 0, '0, '0, '0);
        chk("R7 err sticky", {60'b0, seed_err}, 61'h1);
        cycle(0, 1, '0, '0, 61'h3);
        compare_all("R7 shift with err");
        cycle(1, 0, 61'h2, 61'h7, '0);
        compare_all("R7 cleared by good load");
    endtask

    task automatic t_match();
        expect_sig = m_sig;
        #1 chk("R8 match high", {60'b0, sig_match}, 61'h1);
        expect_sig = m_sig ^ 61'h1;
        #1 chk("R8 match low bit0", {60'b0, sig_match}, '0);
        expect_sig = m_sig ^ (61'h1 << 60);
        #1 chk("R8 match low bit60", {60'b0, sig_match}, '0);
        for (int k = 0; k < 20; k++) cycle(0, 1, '0, '0, 61'h1F << (k % 40));
        expect_sig = m_sig;
        #1 chk("R8 match after run", {60'b0, sig_match}, 61'h1);
    endtask

    initial begin
        t_reset();
        t_load_and_free_run();
        t_patterns();
        t_hold();
        t_load_wins();
        t_zero_seed();
        t_match();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule